// File: doc/BRIEF.md
# SD Host Data-Port Buffer

This block sits between the bus-facing register file of an SD/MMC host controller and the card-side data engine. A single word-wide FIFO carries data in either direction. On a read transfer the card side streams words in and the host drains them through a data-port register. On a write transfer the host fills the buffer through the same port and the card side drains it.

Software programs a block count and a block size, plus separate read and write thresholds counted in 32-bit words. It then starts a transfer in the chosen direction. For each block the buffer raises a ready status once enough words, or enough free space, are present. Software moves exactly one block of words and then clears the ready flag. Once the final block has moved, a transfer-complete status is set.

Status bits are write-one-to-clear and gated by an enable mask. Data-port misuse is reported in the upper, error half of the status word.

Top module: `sdh_dbuf_top`

## Requirements
- R1: After reset the status, status-enable, block-configuration and threshold registers read 0, `xfer_fail` is 0, `card_in_ready` is 0 and `card_out_valid` is 0.
- R2: The block-configuration register (address 0) holds the block count in bits 31:16 and the block size in bytes in bits 15:0. A write whose size is not a multiple of 4 (bits 1:0 non-zero) is ignored as a whole.
- R3: The threshold register (address 1) holds the read threshold in bits 15:0 and the write threshold in bits 31:16, both in words. A written value above 128 (the buffer depth) is stored and read back as 128.
- R4: During a read transfer, read-ready (status bit 2) is recorded once per block, when the buffered word count reaches the read threshold and no earlier read-ready is still pending. It is not recorded while fewer words are buffered.
- R5: During a write transfer, write-ready (status bit 1) is recorded once per block, when free space reaches the write threshold and no earlier write-ready is still pending.
- R6: A block ends after size/4 accepted data-port words. Transfer-complete (status bit 0) is recorded only after the last counted block. For a write, the buffer must also have drained to the card side. A block count of 0 completes at once.
- R7: Writing the status register (address 4) clears exactly the bits written as 1. Writing all ones clears every pending bit.
- R8: The status-enable register (address 5) resets to 0. An event whose enable bit is 0 is not recorded, and a status read returns pending bits ANDed with the enable mask.
- R9: A data-port read (address 2) with the buffer empty, or during a write transfer, returns 0 and records underrun (status bit 16).
- R10: A data-port write with the buffer full, or during a read transfer, is dropped and records overrun (status bit 17).
- R11: `xfer_fail` is 1 exactly when any visible status bit in 31:16 is set.
- R12: Words leave the buffer in the order they entered, in both directions. `card_in_ready` is raised only during a read transfer. Writing the start register (address 3, bit 0 = 1 for read, 0 for write) empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| card_in_valid | input | 1 | Card side offers a word (read transfer) |
| card_in_data | input | 32 | Word from the card side |
| card_in_ready | output | 1 | Buffer accepts a card word |
| card_out_valid | output | 1 | Buffer offers a word to the card side (write transfer) |
| card_out_data | output | 32 | Word to the card side |
| card_out_ready | input | 1 | Card side takes the offered word |
| xfer_fail | output | 1 | Any enabled error status pending |

## Verification
The bench builds the block with its default depth of 128 words and a threshold limit equal to that depth. A 129-word burst therefore reaches the full-buffer overrun path. Threshold writes of 0x200 and 0x300 exercise the clamp. Small blocks of 4 and 2 words with thresholds equal to the block length make every block boundary visible. They also expose the gating of the second ready by the still-pending first one, and they allow a partial fill to be observed below the read threshold.

// File: rtl/sdh_dbuf_pkg.sv
package sdh_dbuf_pkg;
   typedef enum logic [2:0] {
      A_BLKCFG = 3'd0,
      A_WMARK  = 3'd1,
      A_DATA   = 3'd2,
      A_START  = 3'd3,
      A_STATUS = 3'd4,
      A_ENABLE = 3'd5
   } reg_addr_e;

   localparam int ST_DONE  = 0;
   localparam int ST_WRRDY = 1;
   localparam int ST_RDRDY = 2;
   localparam int ST_UNDER = 16;
   localparam int ST_OVER  = 17;
   localparam int REG_W    = 32;
   localparam int HALF_W   = 16;
endpackage

// File: rtl/sdh_dbuf_fifo.sv
module sdh_dbuf_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sdh_dbuf_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   assign rdata = mem[rptr];
   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R10: the caller must drop words instead of pushing into a full buffer
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R9: the caller must not pop an empty buffer
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/sdh_dbuf_blkctl.sv
module sdh_dbuf_blkctl #(
   parameter int DEPTH = 128,
   parameter int CW    = 16,
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [CW-1:0] blk_cnt,
   input  logic [CW-1:0] blk_words,
   input  logic [LW-1:0] rd_wm,
   input  logic [LW-1:0] wr_wm,
   input  logic [LW-1:0] level,
   input  logic          host_word,
   input  logic          rd_pend,
   input  logic          wr_pend,
   output logic          active,
   output logic          dir_rd,
   output logic          ev_rd,
   output logic          ev_wr,
   output logic          ev_done
);
   logic [CW-1:0] left, wcnt;
   logic          raised;
   logic [LW-1:0] space;

   always_comb begin
      space   = LW'(DEPTH) - level;
      ev_rd   = active &&  dir_rd && !raised && (left != '0) && !rd_pend && (level >= rd_wm);
      ev_wr   = active && !dir_rd && !raised && (left != '0) && !wr_pend && (space >= wr_wm);
      ev_done = active && (left == '0) && (dir_rd || level == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         dir_rd <= 1'b0;
         left   <= '0;
         wcnt   <= '0;
         raised <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         dir_rd <= start_rd;
         left   <= blk_cnt;
         wcnt   <= '0;
         raised <= 1'b0;
      end else begin
         if (ev_done) active <= 1'b0;
         if (ev_rd || ev_wr) raised <= 1'b1;
         if (host_word && active && left != '0) begin
            if (wcnt == blk_words - 1'b1) begin
               wcnt   <= '0;
               raised <= 1'b0;
               left   <= left - 1'b1;
            end else begin
               wcnt <= wcnt + 1'b1;
            end
         end
      end
   end

   // R4: read-ready is recorded at most once until a block boundary
   assert_rd_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !start) |=> !ev_rd);
   // R5: write-ready likewise
   assert_wr_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wr && !start) |=> !ev_wr);
   // R6: completion ends the transfer
   assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && !start) |=> !active);
endmodule

// File: rtl/sdh_dbuf_stat.sv
module sdh_dbuf_stat #(
   parameter int SW = 32,
   localparam int HW = SW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] set,
   input  logic          clr_we,
   input  logic [SW-1:0] clr,
   input  logic          en_we,
   input  logic [SW-1:0] en_d,
   output logic [SW-1:0] pend,
   output logic [SW-1:0] vis,
   output logic [SW-1:0] en,
   output logic          fail
);
   generate
      if (SW % 2 != 0) begin : g_bad_sw
         $error("sdh_dbuf_stat: SW must be even");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         en   <= '0;
      end else begin
         pend <= (pend & ~(clr_we ? clr : '0)) | (set & en);
         if (en_we) en <= en_d;
      end
   end

   assign vis  = pend & en;
   assign fail = |vis[SW-1:HW];

   // R8: a bit whose enable was clear cannot become pending
   assert_masked_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(en) & ~$past(pend)) == '0));
   // R7: a cleared bit with no new event stays clear
   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && ((clr & pend & ~set) != '0)) |=> ((pend & $past(clr & ~set)) == '0));
endmodule

// File: rtl/sdh_dbuf_top.sv
module sdh_dbuf_top
   import sdh_dbuf_pkg::*;
#(
   parameter int DEPTH    = 128,
   parameter int WM_LIMIT = DEPTH
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        card_in_valid,
   input  logic [31:0] card_in_data,
   output logic        card_in_ready,
   output logic        card_out_valid,
   output logic [31:0] card_out_data,
   input  logic        card_out_ready,
   output logic        xfer_fail
);
   localparam int LW = $clog2(DEPTH) + 1;

   generate
      if (WM_LIMIT > DEPTH || WM_LIMIT < 1) begin : g_bad_wm
         $error("sdh_dbuf_top: WM_LIMIT must lie in 1..DEPTH");
      end
      if (DEPTH > 32768) begin : g_bad_big
         $error("sdh_dbuf_top: DEPTH must fit a 16-bit threshold field");
      end
   endgenerate

   function automatic logic [LW-1:0] clamp_wm(input logic [HALF_W-1:0] v);
      if (v > HALF_W'(WM_LIMIT)) return LW'(WM_LIMIT);
      return v[LW-1:0];
   endfunction

   logic [REG_W-1:0] blkcfg_q;
   logic [LW-1:0]    wm_rd_q, wm_wr_q;
   logic [REG_W-1:0] set_v, pend, vis, en;
   logic [LW-1:0]    level;
   logic [31:0]      fifo_rdata, fifo_wdata;
   logic             full, empty, active, dir_rd;
   logic             ev_rd, ev_wr, ev_done;
   logic             host_rd_data, host_wr_data, host_pop_ok, host_push_ok;
   logic             underrun_ev, overrun_ev, start, host_word, push, pop;

   always_comb begin
      host_rd_data = bus_rd && (bus_addr == A_DATA);
      host_wr_data = bus_wr && (bus_addr == A_DATA);
      start        = bus_wr && (bus_addr == A_START);
      host_pop_ok  = host_rd_data && !empty && !(active && !dir_rd);
      host_push_ok = host_wr_data && !full  && !(active &&  dir_rd);
      underrun_ev  = host_rd_data && !host_pop_ok;
      overrun_ev   = host_wr_data && !host_push_ok;
      card_in_ready  = active &&  dir_rd && !full;
      card_out_valid = active && !dir_rd && !empty;
      card_out_data  = fifo_rdata;
      push       = host_push_ok || (card_in_valid && card_in_ready);
      fifo_wdata = card_in_ready ? card_in_data : bus_wdata;
      pop        = host_pop_ok || (card_out_valid && card_out_ready);
      host_word  = active && (dir_rd ? host_pop_ok : host_push_ok);
      set_v = '0;
      set_v[ST_DONE]  = ev_done;
      set_v[ST_WRRDY] = ev_wr;
      set_v[ST_RDRDY] = ev_rd;
      set_v[ST_UNDER] = underrun_ev;
      set_v[ST_OVER]  = overrun_ev;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blkcfg_q <= '0;
         wm_rd_q  <= '0;
         wm_wr_q  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_BLKCFG && bus_wdata[1:0] == 2'b00) blkcfg_q <= bus_wdata;
         if (bus_addr == A_WMARK) begin
            wm_rd_q <= clamp_wm(bus_wdata[HALF_W-1:0]);
            wm_wr_q <= clamp_wm(bus_wdata[REG_W-1:HALF_W]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (bus_addr)
            A_BLKCFG: bus_rdata <= blkcfg_q;
            A_WMARK:  bus_rdata <= {HALF_W'(wm_wr_q), HALF_W'(wm_rd_q)};
            A_DATA:   bus_rdata <= host_pop_ok ? fifo_rdata : '0;
            A_STATUS: bus_rdata <= vis;
            A_ENABLE: bus_rdata <= en;
            default:  bus_rdata <= '0;
         endcase
      end
   end

   sdh_dbuf_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(start), .push(push), .wdata(fifo_wdata),
      .pop(pop), .rdata(fifo_rdata), .level(level), .full(full), .empty(empty)
   );

   sdh_dbuf_blkctl #(.DEPTH(DEPTH), .CW(HALF_W)) u_blk (
      .clk(clk), .rst_n(rst_n), .start(start), .start_rd(bus_wdata[0]),
      .blk_cnt(blkcfg_q[REG_W-1:HALF_W]), .blk_words({2'b00, blkcfg_q[HALF_W-1:2]}),
      .rd_wm(wm_rd_q), .wr_wm(wm_wr_q), .level(level), .host_word(host_word),
      .rd_pend(pend[ST_RDRDY]), .wr_pend(pend[ST_WRRDY]),
      .active(active), .dir_rd(dir_rd), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_done(ev_done)
   );

   sdh_dbuf_stat #(.SW(REG_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(set_v),
      .clr_we(bus_wr && bus_addr == A_STATUS), .clr(bus_wdata),
      .en_we(bus_wr && bus_addr == A_ENABLE), .en_d(bus_wdata),
      .pend(pend), .vis(vis), .en(en), .fail(xfer_fail)
   );

   // R9: a refused data-port read returns zero on the bus
   assert_underrun_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_ev |=> (bus_rdata == '0));
   // R12: the card side is offered space only while a read transfer runs
   assert_card_in_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      card_in_ready |-> (active && dir_rd));
endmodule

// File: tb/tb_sdh_dbuf_top.sv
`timescale 1ns/1ps
module tb_sdh_dbuf_top;
   localparam real CLK_NS = 8.0;
   localparam int  DEPTH  = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        card_in_valid = 1'b0;
   logic [31:0] card_in_data = '0;
   logic        card_in_ready;
   logic        card_out_valid;
   logic [31:0] card_out_data;
   logic        card_out_ready = 1'b1;
   logic        xfer_fail;

   int errs = 0, checks = 0;
   bit finished = 0;
   logic [31:0] rdq[$];
   logic [31:0] wrq[$];

   always #(CLK_NS/2) clk = ~clk;

   sdh_dbuf_top #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_in_valid(card_in_valid),
      .card_in_data(card_in_data), .card_in_ready(card_in_ready),
      .card_out_valid(card_out_valid), .card_out_data(card_out_data),
      .card_out_ready(card_out_ready), .xfer_fail(xfer_fail)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic card_push(logic [31:0] d);
      @(negedge clk);
      while (!card_in_ready) @(negedge clk);
      card_in_valid = 1'b1; card_in_data = d;
      rdq.push_back(d);
      @(negedge clk);
      card_in_valid = 1'b0;
   endtask

   task automatic host_read_word(string req);
      logic [31:0] v, e;
      rd(3'd2, v);
      e = (rdq.size() > 0) ? rdq.pop_front() : 32'hDEAD_BEEF;
      check(req, v, e);
   endtask

   task automatic host_write_word(logic [31:0] d);
      wrq.push_back(d);
      wr(3'd2, d);
   endtask

   task automatic wait_bit(int b, string req);
      logic [31:0] v;
      for (int i = 0; i < 300; i++) begin
         rd(3'd4, v);
         if (v[b]) break;
      end
      check(req, 32'(v[b]), 32'd1);
   endtask

   // monitor: card side of a write transfer
   always @(negedge clk) begin
      if (rst_n && card_out_valid && card_out_ready) begin
         checks++;
         if (wrq.size() == 0) begin
            errs++;
            $display("FAIL R12: actual=%h expected=<none>", card_out_data);
         end else begin
            logic [31:0] e;
            e = wrq.pop_front();
            if (card_out_data !== e) begin
               errs++;
               $display("FAIL R12: actual=%h expected=%h", card_out_data, e);
            end
         end
      end
   end

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", 32'(xfer_fail), 0);
      check("R1", 32'(card_in_ready), 0);
      check("R1", 32'(card_out_valid), 0);
      rd(3'd4, v); check("R1", v, 0);
      rd(3'd5, v); check("R1", v, 0);
      rd(3'd0, v); check("R1", v, 0);
      rd(3'd1, v); check("R1", v, 0);

      // R8 masked event not recorded; R9 empty read returns 0
      rd(3'd2, v); check("R9", v, 0);
      rd(3'd4, v); check("R8", v, 0);
      check("R8", 32'(xfer_fail), 0);
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, v); check("R8", v, 32'hFFFF_FFFF);
      rd(3'd4, v); check("R8", v, 0);

      // R2 block config and multiple-of-4 rule
      wr(3'd0, 32'h0002_0010);
      rd(3'd0, v); check("R2", v, 32'h0002_0010);
      wr(3'd0, 32'h0005_0012);
      rd(3'd0, v); check("R2", v, 32'h0002_0010);

      // R3 threshold clamp
      wr(3'd1, 32'h0300_0200);
      rd(3'd1, v); check("R3", v, 32'h0080_0080);
      wr(3'd1, 32'h0004_0004);
      rd(3'd1, v); check("R3", v, 32'h0004_0004);

      // Read transfer: 2 blocks of 4 words
      wr(3'd3, 32'h1);
      check("R12", 32'(card_in_ready), 1);
      for (int i = 0; i < 3; i++) card_push(32'hA000_0000 + 32'(i));
      repeat (3) @(negedge clk);
      rd(3'd4, v); check("R4", v, 0);
      for (int i = 3; i < 8; i++) card_push(32'hA000_0000 + 32'(i));
      wait_bit(2, "R4");
      for (int i = 0; i < 4; i++) host_read_word("R12");
      rd(3'd4, v); check("R6", v, 32'h4);
      wr(3'd4, 32'h4);
      wait_bit(2, "R4");
      for (int i = 0; i < 4; i++) host_read_word("R12");
      wr(3'd4, 32'h4);
      wait_bit(0, "R6");
      rd(3'd4, v); check("R6", v, 32'h1);
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); check("R7", v, 0);

      // Write transfer: 3 blocks of 2 words
      wr(3'd0, 32'h0003_0008);
      wr(3'd1, 32'h0002_0002);
      wr(3'd3, 32'h0);
      check("R12", 32'(card_in_ready), 0);
      for (int b = 0; b < 3; b++) begin
         wait_bit(1, "R5");
         host_write_word(32'hB000_0000 + 32'(2*b));
         host_write_word(32'hB000_0001 + 32'(2*b));
         wr(3'd4, 32'h2);
      end
      wait_bit(0, "R6");
      check("R12", 32'(wrq.size()), 0);
      wr(3'd4, 32'hFFFF_FFFF);

      // R10 overrun at full buffer with no transfer running
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'(i);
      end
      @(negedge clk); bus_wr = 1'b0;
      rd(3'd4, v); check("R10", v, 0);
      wr(3'd2, 32'h1234_5678);
      rd(3'd4, v); check("R10", v, 32'h0002_0000);
      check("R11", 32'(xfer_fail), 1);

      // R12 start flushes; zero-count transfer completes at once
      wr(3'd0, 32'h0000_0010);
      wr(3'd3, 32'h1);
      rd(3'd2, v); check("R9", v, 0);
      rd(3'd4, v); check("R6", v, 32'h0003_0001);
      wr(3'd4, 32'h0001_0000);
      rd(3'd4, v); check("R7", v, 32'h0002_0001);
      check("R11", 32'(xfer_fail), 1);
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); check("R7", v, 0);
      check("R11", 32'(xfer_fail), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule